// File: doc/BRIEF.md
# Serial Configuration Register Slave for a Satellite Tuner

This block lets a two-wire bus master configure a tuner. Its own system clock samples the bus lines; it does not use SCL as a clock. Behind the bus slave sit twelve writable 8-bit configuration registers at pointers 0x00 to 0x0B and two read-only status registers at 0x0C and 0x0D. The master can write several registers in one transfer, because the register pointer steps forward after each byte. To read, the master first sets the pointer with a write, then sends a repeated START with the read bit set. It keeps reading successive registers until it answers with NACK.

The device address is 110000 followed by the strap input, so the write/read address bytes are 0xC0/0xC1 or 0xC2/0xC3. Every configuration register appears on a flat output bus. A write to pointer 0x04, the low byte of the fractional divider, raises a one-clock strobe that starts the oscillator band search. A power-on flag in the first status register stays set after reset until a transfer that read that register ends with STOP.

The sequencer states are IDLE, DEV (address byte in), DEV_ACK, PTR (pointer byte in), PTR_ACK, WDAT (data byte in), WDAT_ACK, RDAT (byte out), RACK (master acknowledge) and IGNORE.
- A START in any state enters DEV. A STOP in any state enters IDLE.
- At the ninth falling SCL edge, DEV goes to DEV_ACK on an address match and to IGNORE otherwise.
- DEV_ACK goes to RDAT for a read and to PTR for a write.
- PTR goes to PTR_ACK, then to WDAT. WDAT goes to WDAT_ACK and back to WDAT.
- RDAT goes to RACK after eight bits. RACK goes back to RDAT on ACK and to IGNORE on NACK.

Top module: `i2c_tuner_regs`

## Requirements
- R1: The slave acknowledges an address byte whose upper seven bits equal 110000 followed by `addr_sel`. It does so by driving SDA low during the ninth SCL clock. An address byte built for the other strap value is not acknowledged.
- R2: After an address byte that does not match, `sda_oe` stays low and no register changes until the next START.
- R3: In a write transfer, the first byte after the address is the register pointer. Each following data byte is acknowledged and lands in the register at the pointer, and the pointer then steps by one.
- R4: After a repeated START with the read bit set, the slave sends registers MSB first, starting at the pointer and stepping by one. It continues while the master acknowledges and stops sending after a NACK.
- R5: After reset the registers hold 0x00=0x80, 0x01=0x23, 0x02=0x02, 0x03=0xF6, 0x04=0x84, 0x05=0x01, 0x06=0xC0, 0x07=0xCC, 0x08=0x4B, 0x09=0x00, 0x0A=0x00 and 0x0B=0x08. Register k appears on `cfg_regs[8k+7:8k]`.
- R6: Each write to pointer 0x04 raises `vas_start` for exactly one clock. Writes to other pointers do not raise it.
- R7: Status register 0x0C reads as {power-on flag, `stat_flags[2:0]`, 0000}, and 0x0D reads as `stat_aux`. Writes to 0x0C and 0x0D are acknowledged and change nothing.
- R8: The power-on flag is 1 after reset and stays 1 while a transfer reads 0x0C. It clears when such a transfer ends with STOP. Reads of other registers leave it set, and once clear it stays clear.
- R9: `standby` equals bit 7 of register 0x09, and `bb_gain` equals bits 3..0 of that register.
- R10: A pulse on SCL or SDA shorter than GLITCH_LEN system clocks is filtered out and does not disturb a transfer.
- R11: `sda_oe` changes only while the filtered SCL is low.
- R12: Reads from pointers above 0x0D return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| addr_sel | input | 1 | Strap that sets the lowest device address bit |
| stat_flags | input | 3 | Band-search and lock flags shown in status 0x0C bits 6..4 |
| stat_aux | input | 8 | Value returned for status 0x0D |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain enable) |
| cfg_regs | output | 96 | All twelve configuration registers, register k in bits 8k+7..8k |
| vas_start | output | 1 | One-clock strobe after a write to pointer 0x04 |
| standby | output | 1 | Standby control taken from register 0x09 |
| bb_gain | output | 4 | Baseband gain code taken from register 0x09 |

## Verification
The bound checker watches four things on every clock:
- `sda_oe` changes only while SCL is low.
- The configuration bus moves only in the clock after an internal write event.
- The band-search strobe lasts one clock and always follows a write.
- The power-on flag never returns once cleared.

Some behaviour shows only in whole bus transfers driven by the bench scenarios. This covers address matching against the strap, pointer stepping across a burst, the repeated-START read path, the status byte layout, the flag clearing at STOP rather than at the read, discarded writes, and rejection of short SCL glitches.

// File: rtl/tuner_i2c_pkg.sv
package tuner_i2c_pkg;
    localparam int REG_W       = 8;
    localparam int PTR_W       = 8;
    localparam logic [5:0] DEV_PREFIX = 6'b110000;
    localparam int VAS_IDX     = 4;
    localparam int CTRL_IDX    = 9;

    typedef enum logic [3:0] {
        ST_IDLE, ST_DEV, ST_DEV_ACK, ST_PTR, ST_PTR_ACK,
        ST_WDAT, ST_WDAT_ACK, ST_RDAT, ST_RACK, ST_IGNORE
    } slv_state_t;

    function automatic logic [REG_W-1:0] reg_default(input int idx);
        case (idx)
            0:       return 8'h80;
            1:       return 8'h23;
            2:       return 8'h02;
            3:       return 8'hF6;
            4:       return 8'h84;
            5:       return 8'h01;
            6:       return 8'hC0;
            7:       return 8'hCC;
            8:       return 8'h4B;
            11:      return 8'h08;
            default: return 8'h00;
        endcase
    endfunction
endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
    parameter int LINES      = 2,
    parameter int GLITCH_LEN = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] raw,
    output logic [LINES-1:0] level,
    output logic [LINES-1:0] rise,
    output logic [LINES-1:0] fall
);
    localparam int CNT_W = $clog2(GLITCH_LEN + 1);

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic s1, s2, lvl, prev;
        logic [CNT_W-1:0] cnt;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                s1   <= 1'b1;
                s2   <= 1'b1;
                lvl  <= 1'b1;
                prev <= 1'b1;
                cnt  <= '0;
            end else begin
                s1   <= raw[g];
                s2   <= s1;
                prev <= lvl;
                if (s2 != lvl) begin
                    if (cnt == CNT_W'(GLITCH_LEN - 1)) begin
                        lvl <= s2;
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end else begin
                    cnt <= '0;
                end
            end
        end

        assign level[g] = lvl;
        assign rise[g]  = lvl & ~prev;
        assign fall[g]  = ~lvl & prev;
    end
endmodule

// File: rtl/i2c_slave_fsm.sv
module i2c_slave_fsm
    import tuner_i2c_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_rise,
    input  logic             scl_fall,
    input  logic             sda_lvl,
    input  logic             start_ev,
    input  logic             stop_ev,
    input  logic             strap,
    input  logic [REG_W-1:0] rd_data,
    output logic [PTR_W-1:0] ptr,
    output logic             rd_fetch,
    output logic             wr_en,
    output logic [PTR_W-1:0] wr_addr,
    output logic [REG_W-1:0] wr_data,
    output logic             sda_oe
);
    slv_state_t state, nxt;
    logic [3:0]       bitcnt;
    logic [REG_W-1:0] shreg, tx;
    logic             rw, mack;
    logic             byte_end, addr_hit;

    assign byte_end = scl_fall && (bitcnt == 4'd8);
    assign addr_hit = (shreg[7:1] == {DEV_PREFIX, strap});
    assign rd_fetch = scl_fall && !start_ev && !stop_ev &&
                      ((state == ST_DEV_ACK && rw) || (state == ST_RACK && mack));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        if (start_ev)     nxt = ST_DEV;
        else if (stop_ev) nxt = ST_IDLE;
        else begin
            unique case (state)
                ST_IDLE:     nxt = ST_IDLE;
                ST_IGNORE:   nxt = ST_IGNORE;
                ST_DEV:      if (byte_end) nxt = addr_hit ? ST_DEV_ACK : ST_IGNORE;
                ST_DEV_ACK:  if (scl_fall) nxt = rw ? ST_RDAT : ST_PTR;
                ST_PTR:      if (byte_end) nxt = ST_PTR_ACK;
                ST_PTR_ACK:  if (scl_fall) nxt = ST_WDAT;
                ST_WDAT:     if (byte_end) nxt = ST_WDAT_ACK;
                ST_WDAT_ACK: if (scl_fall) nxt = ST_WDAT;
                ST_RDAT:     if (scl_fall && bitcnt == 4'd7) nxt = ST_RACK;
                ST_RACK:     if (scl_fall) nxt = mack ? ST_RDAT : ST_IGNORE;
                default:     nxt = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bitcnt  <= '0;
            shreg   <= '0;
            tx      <= '0;
            rw      <= 1'b0;
            mack    <= 1'b0;
            ptr     <= '0;
            wr_en   <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            wr_en <= 1'b0;
            if (start_ev || stop_ev) begin
                bitcnt <= '0;
            end else if (rd_fetch) begin
                tx     <= rd_data;
                ptr    <= ptr + 1'b1;
                bitcnt <= '0;
            end else begin
                unique case (state)
                    ST_DEV, ST_PTR, ST_WDAT: begin
                        if (scl_rise) begin
                            shreg  <= {shreg[REG_W-2:0], sda_lvl};
                            bitcnt <= bitcnt + 1'b1;
                        end else if (byte_end) begin
                            bitcnt <= '0;
                            if (state == ST_DEV) rw <= shreg[0];
                            if (state == ST_PTR) ptr <= shreg;
                            if (state == ST_WDAT) begin
                                wr_en   <= 1'b1;
                                wr_addr <= ptr;
                                wr_data <= shreg;
                                ptr     <= ptr + 1'b1;
                            end
                        end
                    end
                    ST_RDAT: begin
                        if (scl_fall && bitcnt != 4'd7) begin
                            tx     <= {tx[REG_W-2:0], 1'b0};
                            bitcnt <= bitcnt + 1'b1;
                        end
                    end
                    ST_RACK: begin
                        if (scl_rise) mack <= ~sda_lvl;
                    end
                    default: bitcnt <= '0;
                endcase
            end
        end
    end

    always_comb begin
        sda_oe = 1'b0;
        unique case (state)
            ST_DEV_ACK, ST_PTR_ACK, ST_WDAT_ACK: sda_oe = 1'b1;
            ST_RDAT:                             sda_oe = ~tx[REG_W-1];
            default:                             sda_oe = 1'b0;
        endcase
    end
endmodule

// File: rtl/tuner_reg_bank.sv
module tuner_reg_bank
    import tuner_i2c_pkg::*;
#(
    parameter int NUM_WR = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [PTR_W-1:0]        wr_addr,
    input  logic [REG_W-1:0]        wr_data,
    input  logic [PTR_W-1:0]        rd_ptr,
    input  logic                    rd_fetch,
    input  logic                    stop_ev,
    input  logic [2:0]              stat_flags,
    input  logic [REG_W-1:0]        stat_aux,
    output logic [REG_W-1:0]        rd_data,
    output logic [NUM_WR*REG_W-1:0] cfg_flat,
    output logic                    vas_start,
    output logic                    por_q
);
    localparam int STAT0 = NUM_WR;
    localparam int STAT1 = NUM_WR + 1;

    logic por_pend;

    for (genvar g = 0; g < NUM_WR; g++) begin : g_reg
        logic [REG_W-1:0] q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                   q <= reg_default(g);
            else if (wr_en && wr_addr == PTR_W'(g))       q <= wr_data;
        end
        assign cfg_flat[g*REG_W +: REG_W] = q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vas_start <= 1'b0;
            por_q     <= 1'b1;
            por_pend  <= 1'b0;
        end else begin
            vas_start <= wr_en && (wr_addr == PTR_W'(VAS_IDX));
            if (rd_fetch && rd_ptr == PTR_W'(STAT0)) por_pend <= 1'b1;
            if (stop_ev) begin
                por_pend <= 1'b0;
                if (por_pend) por_q <= 1'b0;
            end
        end
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_WR; i++)
            if (rd_ptr == PTR_W'(i)) rd_data = cfg_flat[i*REG_W +: REG_W];
        if (rd_ptr == PTR_W'(STAT0)) rd_data = {por_q, stat_flags, 4'b0000};
        if (rd_ptr == PTR_W'(STAT1)) rd_data = stat_aux;
    end
endmodule

// File: rtl/i2c_tuner_regs.sv
module i2c_tuner_regs
    import tuner_i2c_pkg::*;
#(
    parameter int NUM_WR     = 12,
    parameter int GLITCH_LEN = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    scl_i,
    input  logic                    sda_i,
    input  logic                    addr_sel,
    input  logic [2:0]              stat_flags,
    input  logic [REG_W-1:0]        stat_aux,
    output logic                    sda_oe,
    output logic [NUM_WR*REG_W-1:0] cfg_regs,
    output logic                    vas_start,
    output logic                    standby,
    output logic [3:0]              bb_gain
);
    localparam int CFG_W = NUM_WR * REG_W;

    logic [1:0] lvl, rise, fall;
    logic scl_lvl, sda_lvl, start_ev, stop_ev;
    logic [PTR_W-1:0] ptr, wr_addr;
    logic [REG_W-1:0] rd_data, wr_data;
    logic rd_fetch, wr_en, por_q;

    i2c_line_filter #(.LINES(2), .GLITCH_LEN(GLITCH_LEN)) u_filt (
        .clk(clk), .rst_n(rst_n), .raw({sda_i, scl_i}),
        .level(lvl), .rise(rise), .fall(fall)
    );

    assign scl_lvl  = lvl[0];
    assign sda_lvl  = lvl[1];
    assign start_ev = fall[1] & scl_lvl;
    assign stop_ev  = rise[1] & scl_lvl;

    i2c_slave_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .scl_rise(rise[0]), .scl_fall(fall[0]),
        .sda_lvl(sda_lvl), .start_ev(start_ev), .stop_ev(stop_ev),
        .strap(addr_sel), .rd_data(rd_data), .ptr(ptr), .rd_fetch(rd_fetch),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .sda_oe(sda_oe)
    );

    tuner_reg_bank #(.NUM_WR(NUM_WR)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_ptr(ptr), .rd_fetch(rd_fetch), .stop_ev(stop_ev),
        .stat_flags(stat_flags), .stat_aux(stat_aux), .rd_data(rd_data),
        .cfg_flat(cfg_regs), .vas_start(vas_start), .por_q(por_q)
    );

    assign standby = cfg_regs[CTRL_IDX*REG_W + 7];
    assign bb_gain = cfg_regs[CTRL_IDX*REG_W +: 4];
endmodule

// File: rtl/tuner_regs_chk.sv
module tuner_regs_chk #(
    parameter int CFG_W = 96
) (
    input logic             clk,
    input logic             rst_n,
    input logic             scl_f,
    input logic             sda_oe,
    input logic             wr_en,
    input logic             vas_start,
    input logic             por_q,
    input logic [CFG_W-1:0] cfg
);
    // R11
    sda_edge_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_f);

    // R3
    cfg_only_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cfg) |-> $past(wr_en));

    // R6
    vas_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vas_start |-> $past(wr_en));

    // R6
    vas_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vas_start |=> !vas_start);

    // R8
    por_sticky_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !por_q |=> !por_q);
endmodule

bind i2c_tuner_regs tuner_regs_chk #(.CFG_W(CFG_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .scl_f(scl_lvl), .sda_oe(sda_oe),
    .wr_en(wr_en), .vas_start(vas_start), .por_q(por_q), .cfg(cfg_regs)
);

// File: tb/sim_i2c_tuner_regs.sv
module sim_i2c_tuner_regs;
    localparam int CLK_PERIOD = 10;
    localparam int Q          = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1, sda_m = 1'b1, addr_sel = 1'b0;
    logic [2:0] stat_flags = 3'b101;
    logic [7:0] stat_aux = 8'h5A;
    logic sda_oe, vas_start, standby;
    logic [3:0] bb_gain;
    logic [95:0] cfg_regs;
    logic sda_line;

    int tests = 0, fails = 0;
    int vas_hi = 0, vas_rise = 0, oe_hits = 0;
    logic vas_prev = 1'b0, watch_oe = 1'b0, done = 1'b0;

    assign sda_line = sda_m & ~sda_oe;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_tuner_regs u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .addr_sel(addr_sel), .stat_flags(stat_flags), .stat_aux(stat_aux),
        .sda_oe(sda_oe), .cfg_regs(cfg_regs), .vas_start(vas_start),
        .standby(standby), .bb_gain(bb_gain)
    );

    always @(posedge clk) begin
        vas_prev <= vas_start;
        if (vas_start) vas_hi <= vas_hi + 1;
        if (vas_start && !vas_prev) vas_rise <= vas_rise + 1;
        if (watch_oe && sda_oe) oe_hits <= oe_hits + 1;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic qwait();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; qwait(); scl_m = 1'b1; qwait();
        sda_m = 1'b0; qwait(); scl_m = 1'b0; qwait();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; qwait(); scl_m = 1'b1; qwait(); sda_m = 1'b1; qwait();
    endtask

    task automatic send_byte(input logic [7:0] b, input bit glitch, output bit acked);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; qwait(); scl_m = 1'b1;
            if (glitch) begin
                repeat (Q) @(negedge clk);
                scl_m = 1'b0; @(negedge clk); scl_m = 1'b1;
                repeat (Q - 1) @(negedge clk);
            end else begin
                qwait(); qwait();
            end
            scl_m = 1'b0;
        end
        sda_m = 1'b1; qwait(); scl_m = 1'b1; qwait();
        acked = (sda_line == 1'b0);
        qwait(); scl_m = 1'b0; qwait();
    endtask

    task automatic recv_byte(input bit mack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            qwait(); scl_m = 1'b1; qwait();
            b[i] = sda_line;
            qwait(); scl_m = 1'b0;
        end
        qwait(); sda_m = mack ? 1'b0 : 1'b1; qwait();
        scl_m = 1'b1; qwait(); qwait(); scl_m = 1'b0; qwait();
        sda_m = 1'b1;
    endtask

    function automatic logic [7:0] reg_of(input int k);
        return cfg_regs[k*8 +: 8];
    endfunction

    task automatic set_ptr_then_read(input logic [7:0] dev_w, input logic [7:0] p);
        bit a;
        bus_start();
        send_byte(dev_w, 1'b0, a); chk("R1 addr ack", a, 1);
        send_byte(p, 1'b0, a);     chk("R3 ptr ack", a, 1);
        bus_start();
        send_byte(dev_w | 8'h01, 1'b0, a); chk("R4 read addr ack", a, 1);
    endtask

    task automatic t_reset();
        chk("R5 reg00", reg_of(0), 8'h80);  chk("R5 reg01", reg_of(1), 8'h23);
        chk("R5 reg02", reg_of(2), 8'h02);  chk("R5 reg03", reg_of(3), 8'hF6);
        chk("R5 reg04", reg_of(4), 8'h84);  chk("R5 reg05", reg_of(5), 8'h01);
        chk("R5 reg06", reg_of(6), 8'hC0);  chk("R5 reg07", reg_of(7), 8'hCC);
        chk("R5 reg08", reg_of(8), 8'h4B);  chk("R5 reg09", reg_of(9), 8'h00);
        chk("R5 reg0A", reg_of(10), 8'h00); chk("R5 reg0B", reg_of(11), 8'h08);
        chk("R11 sda released", sda_oe, 0);
        chk("R9 standby reset", standby, 0);
    endtask

    task automatic t_rd_default();
        logic [7:0] d;
        set_ptr_then_read(8'hC0, 8'h00);
        recv_byte(1'b1, d); chk("R4 burst byte0", d, 8'h80);
        recv_byte(1'b1, d); chk("R4 burst byte1", d, 8'h23);
        recv_byte(1'b0, d); chk("R4 burst byte2", d, 8'h02);
        bus_stop();
    endtask

    task automatic t_por();
        logic [7:0] d;
        set_ptr_then_read(8'hC0, 8'h0C);
        recv_byte(1'b1, d); chk("R8 flag set before STOP", d, 8'hD0);
        recv_byte(1'b0, d); chk("R7 status 0x0D", d, 8'h5A);
        bus_stop();
        set_ptr_then_read(8'hC0, 8'h0C);
        recv_byte(1'b0, d); chk("R8 flag cleared after STOP", d, 8'h50);
        bus_stop();
    endtask

    task automatic t_write_multi();
        bit a;
        logic [7:0] d;
        int v0 = vas_rise;
        bus_start();
        send_byte(8'hC0, 1'b0, a); chk("R1 write addr ack", a, 1);
        send_byte(8'h03, 1'b0, a);
        send_byte(8'h11, 1'b0, a); chk("R3 data ack 0", a, 1);
        send_byte(8'h22, 1'b0, a); chk("R3 data ack 1", a, 1);
        send_byte(8'h33, 1'b0, a); chk("R3 data ack 2", a, 1);
        bus_stop();
        chk("R3 reg03", reg_of(3), 8'h11);
        chk("R3 reg04", reg_of(4), 8'h22);
        chk("R3 reg05", reg_of(5), 8'h33);
        chk("R6 one strobe", vas_rise, v0 + 1);
        chk("R6 strobe width", vas_hi, vas_rise);
        set_ptr_then_read(8'hC0, 8'h03);
        recv_byte(1'b1, d); chk("R4 readback 03", d, 8'h11);
        recv_byte(1'b1, d); chk("R4 readback 04", d, 8'h22);
        recv_byte(1'b0, d); chk("R4 readback 05", d, 8'h33);
        bus_stop();
    endtask

    task automatic t_ctrl();
        bit a;
        int v0 = vas_rise;
        bus_start();
        send_byte(8'hC0, 1'b0, a); send_byte(8'h09, 1'b0, a);
        send_byte(8'h8A, 1'b0, a);
        bus_stop();
        chk("R9 standby", standby, 1);
        chk("R9 gain", bb_gain, 4'hA);
        chk("R6 no strobe other reg", vas_rise, v0);
    endtask

    task automatic t_mismatch();
        bit a;
        watch_oe = 1'b1;
        bus_start();
        send_byte(8'hC2, 1'b0, a); chk("R2 no ack wrong addr", a, 0);
        send_byte(8'h00, 1'b0, a);
        send_byte(8'h55, 1'b0, a);
        bus_stop();
        watch_oe = 1'b0;
        chk("R2 sda never driven", oe_hits, 0);
        chk("R2 reg00 unchanged", reg_of(0), 8'h80);
    endtask

    task automatic t_readonly();
        bit a;
        logic [7:0] d;
        logic [95:0] snap = cfg_regs;
        bus_start();
        send_byte(8'hC0, 1'b0, a); send_byte(8'h0C, 1'b0, a);
        send_byte(8'hFF, 1'b0, a); chk("R7 ro write ack 0C", a, 1);
        send_byte(8'h00, 1'b0, a); chk("R7 ro write ack 0D", a, 1);
        bus_stop();
        chk("R7 config untouched", (cfg_regs == snap), 1);
        set_ptr_then_read(8'hC0, 8'h0C);
        recv_byte(1'b1, d); chk("R7 status 0x0C kept", d, 8'h50);
        recv_byte(1'b0, d); chk("R7 status 0x0D kept", d, 8'h5A);
        bus_stop();
    endtask

    task automatic t_beyond();
        logic [7:0] d;
        set_ptr_then_read(8'hC0, 8'h0D);
        recv_byte(1'b1, d); chk("R7 status 0x0D", d, 8'h5A);
        recv_byte(1'b0, d); chk("R12 past end reads zero", d, 8'h00);
        bus_stop();
    endtask

    task automatic t_glitch();
        bit a;
        bus_start();
        send_byte(8'hC0, 1'b1, a); chk("R10 ack with glitches", a, 1);
        send_byte(8'h08, 1'b1, a);
        send_byte(8'h3C, 1'b1, a);
        bus_stop();
        chk("R10 reg08 written", reg_of(8), 8'h3C);
    endtask

    task automatic t_strap();
        bit a;
        addr_sel = 1'b1;
        qwait();
        bus_start();
        send_byte(8'hC2, 1'b0, a); chk("R1 strap high ack", a, 1);
        send_byte(8'h00, 1'b0, a);
        send_byte(8'h5C, 1'b0, a);
        bus_stop();
        chk("R1 strap write reg00", reg_of(0), 8'h5C);
        bus_start();
        send_byte(8'hC0, 1'b0, a); chk("R1 other strap no ack", a, 0);
        bus_stop();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_rd_default();
        t_por();
        t_write_multi();
        t_ctrl();
        t_mismatch();
        t_readonly();
        t_beyond();
        t_glitch();
        t_strap();
        finish_run();
    end
endmodule